// File: doc/BRIEF.md
# I2C Master Start and Address Sequencer

This block is the master-side front end of an I2C controller. Software programs an addressing request: 7-bit or 10-bit mode, a 10-bit slave address, the direction, a header-only option for 10-bit reads, and a transfer length. It then raises a start request. The sequencer handles the rest of the address phase:

- It waits for the bus to be free, or issues a repeated START if the bus is already held.
- It times every interval with two programmable counts, one for SCL low and one for SCL high.
- It drives the START condition and shifts out one or two address bytes, MSB first.
- It samples the acknowledge bit after each byte.

When the address phase ends, a one-cycle done pulse and the sampled acknowledge bit hand the bus over to a data-phase engine. Both lines are released at that point.

The SCL-low count is used for three intervals: the bus-free wait before a START, the setup time before a repeated START, and every SCL low phase. The SCL-high count is used for the START hold time and every SCL high phase.

If another master pulls SDA low while this block is releasing it during SCL high, the block loses arbitration. It lets go of both lines on the next cycle, drops the request and raises a slave-mode flag so the slave engine can answer its own address.

Line outputs are open-drain levels: 1 means released and 0 means driven low. For legal bus waveforms, both counts should be at least 1.

Top module: `i2c_addr_seq`

## Requirements
- R1: After reset, sclOut and sdaOut are 1, and startPending, addrDone, arbLost and slaveMode are 0. ackBit is 1.
- R2: A startSet pulse while idle raises startPending on the next cycle. startPending falls in the same cycle that addrDone or arbLost pulses. A startSet while startPending is 1 has no effect.
- R3: If busBusy is 0 when the request is taken, both lines stay released for sclLowCnt+1 cycles before the START. Any cycle that samples busBusy high restarts that interval.
- R4: If busBusy is 1 when the request is taken, the request is a repeated START. Both lines stay released for a setup time of sclLowCnt+1 cycles with no wait for a free bus.
- R5: The START keeps SCL released for sclHighCnt+1 cycles. SDA falls in the second of those cycles.
- R6: Each bit has SCL low for sclLowCnt+1 cycles, then released for sclHighCnt+1 cycles. SDA takes the new bit in the second low cycle and never rises while SCL stays released during a pending request. Bits go MSB first, and SDA is released in the ninth (acknowledge) bit.
- R7: In 7-bit mode one byte {addr[6:0], rw} is sent. In 10-bit mode the header {5'b11110, addr[9:8], rw} is sent, followed by addr[7:0]. rw is 1 for a read.
- R8: A 10-bit read with the header-only option set sends only the header byte.
- R9: The acknowledge bit is sampled from sdaIn in the last SCL-high cycle of the ninth bit and held on ackBit (0 = ACK). A NACK on the header ends the phase without the low address byte. addrDone pulses for one cycle right after the final high phase, with both lines released.
- R10: sdaIn low during the SCL-high phase of an address bit that the block is releasing causes arbitration loss. The next cycle shows both lines released, a one-cycle arbLost pulse, startPending 0 and slaveMode 1. slaveMode clears when the next start is taken.
- R11: cfgWrEn is ignored while startPending is 1, so the cur* outputs keep their values. When idle, a write is taken on the next edge.
- R12: curCount holds cfgLen, saturated to 255 for any programmed length of 255 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgTenBit | input | 1 | 1 selects 10-bit addressing |
| cfgAddr | input | 10 | Slave address |
| cfgRead | input | 1 | Direction, 1 = read |
| cfgHeadOnly | input | 1 | 10-bit read sends header only |
| cfgLen | input | LEN_W | Requested transfer length |
| startSet | input | 1 | Start request pulse |
| busBusy | input | 1 | Bus busy flag |
| sclLowCnt | input | CNT_W | SCL low / bus-free / setup count |
| sclHighCnt | input | CNT_W | SCL high / START hold count |
| sdaIn | input | 1 | Sampled SDA line |
| sclOut | output | 1 | SCL drive, 0 = pull low |
| sdaOut | output | 1 | SDA drive, 0 = pull low |
| startPending | output | 1 | Start request outstanding |
| addrDone | output | 1 | Address phase finished pulse |
| ackBit | output | 1 | Last sampled acknowledge, 0 = ACK |
| arbLost | output | 1 | Arbitration loss pulse |
| slaveMode | output | 1 | Fell back to slave after arbitration loss |
| curTenBit | output | 1 | Held addressing mode |
| curAddr | output | 10 | Held slave address |
| curRead | output | 1 | Held direction |
| curHeadOnly | output | 1 | Held header-only option |
| curCount | output | 8 | Held, saturated transfer length |

## Verification
The embedded properties watch a few rules on every cycle:

- SDA never rises while SCL is released during a request, so no false STOP is produced.
- The held configuration never moves while a request is pending.
- addrDone and arbLost clear the request, and addrDone is a single-cycle pulse.
- arbLost is always accompanied by slaveMode.

The exact interval lengths, the bus-free restart on busBusy, the repeated-START path, the address byte formats, the header-only and NACK-on-header endings, and the exact cycle of arbitration release can only be shown by the bench scenarios. A behavioural reference trace checks these cycle by cycle.

// File: rtl/i2c_addr_seq_pkg.sv
package i2c_addr_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BUF,
    S_SETUP,
    S_HOLD,
    S_BLOW,
    S_BHIGH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgLock;
    logic sdaHi;
    logic sdaLo;
    logic loadLow;
    logic loadHigh;
    logic loadFirst;
    logic loadSecond;
    logic shiftBit;
    logic captureAck;
  } seqStrobe_t;

endpackage

// File: rtl/i2c_addr_seq_dp.sv
module i2c_addr_seq_dp
  import i2c_addr_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       st,
  input  logic             cfgWrEn,
  input  logic             cfgTenBit,
  input  logic [9:0]       cfgAddr,
  input  logic             cfgRead,
  input  logic             cfgHeadOnly,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic [CNT_W-1:0] sclLowCnt,
  input  logic [CNT_W-1:0] sclHighCnt,
  input  logic             sdaIn,
  output logic             timerZero,
  output logic             lastBit,
  output logic             moreBytes,
  output logic             sdaDrive,
  output logic             ackBit,
  output logic             curTenBit,
  output logic [9:0]       curAddr,
  output logic             curRead,
  output logic             curHeadOnly,
  output logic [7:0]       curCount
);

  localparam int BYTE_BITS = 8;
  localparam int IDX_W     = $clog2(BYTE_BITS + 1);
  localparam int COUNT_MAX = (1 << BYTE_BITS) - 1;

  logic [CNT_W-1:0]     timerQ;
  logic [BYTE_BITS-1:0] shiftQ;
  logic [IDX_W-1:0]     bitIdx;
  logic                 secondQ;
  logic [BYTE_BITS-1:0] firstByte;

  // held configuration, locked while a request is pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curTenBit   <= 1'b0;
      curAddr     <= '0;
      curRead     <= 1'b0;
      curHeadOnly <= 1'b0;
      curCount    <= '0;
    end else if (cfgWrEn && !st.cfgLock) begin
      curTenBit   <= cfgTenBit;
      curAddr     <= cfgAddr;
      curRead     <= cfgRead;
      curHeadOnly <= cfgHeadOnly;
      curCount    <= (cfgLen > LEN_W'(COUNT_MAX)) ? BYTE_BITS'(COUNT_MAX)
                                                  : cfgLen[BYTE_BITS-1:0];
    end
  end

  always_comb begin
    if (curTenBit) firstByte = {5'b11110, curAddr[9:8], curRead};
    else           firstByte = {curAddr[6:0], curRead};
  end

  // interval timer shared by every bus phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timerQ <= '0;
    else if (st.loadLow)      timerQ <= sclLowCnt;
    else if (st.loadHigh)     timerQ <= sclHighCnt;
    else if (timerQ != '0)    timerQ <= timerQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      bitIdx  <= '0;
      secondQ <= 1'b0;
    end else if (st.loadFirst) begin
      shiftQ  <= firstByte;
      bitIdx  <= '0;
      secondQ <= 1'b0;
    end else if (st.loadSecond) begin
      shiftQ  <= curAddr[7:0];
      bitIdx  <= '0;
      secondQ <= 1'b1;
    end else if (st.shiftBit) begin
      shiftQ  <= {shiftQ[BYTE_BITS-2:0], 1'b0};
      bitIdx  <= bitIdx + 1'b1;
    end
  end

  assign timerZero = (timerQ == '0);
  assign lastBit   = (bitIdx == IDX_W'(BYTE_BITS));
  assign moreBytes = !secondQ && curTenBit && !(curRead && curHeadOnly);

  // SDA level registered: new bit appears one cycle after SCL falls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sdaDrive <= 1'b1;
    else if (st.sdaLo)  sdaDrive <= 1'b0;
    else if (st.sdaHi)  sdaDrive <= 1'b1;
    else                sdaDrive <= lastBit ? 1'b1 : shiftQ[BYTE_BITS-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ackBit <= 1'b1;
    else if (st.captureAck) ackBit <= sdaIn;
  end

  // R11
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.cfgLock |=> $stable({curTenBit, curAddr, curRead, curHeadOnly, curCount}));

endmodule

// File: rtl/i2c_addr_seq_ctrl.sv
module i2c_addr_seq_ctrl
  import i2c_addr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startSet,
  input  logic       busBusy,
  input  logic       sdaIn,
  input  logic       timerZero,
  input  logic       lastBit,
  input  logic       moreBytes,
  input  logic       sdaDrive,
  output seqStrobe_t st,
  output logic       sclOut,
  output logic       startPending,
  output logic       addrDone,
  output logic       arbLost,
  output logic       slaveMode
);

  seqState_t state, nxt;
  logic doneNx, arbNx;

  always_comb begin
    st        = '0;
    nxt       = state;
    doneNx    = 1'b0;
    arbNx     = 1'b0;
    st.cfgLock = (state != S_IDLE);
    st.sdaHi   = (state == S_IDLE) || (state == S_BUF) || (state == S_SETUP);
    st.sdaLo   = (state == S_HOLD);
    unique case (state)
      S_IDLE: if (startSet) begin
        st.loadLow = 1'b1;
        nxt = busBusy ? S_SETUP : S_BUF;
      end
      S_BUF: begin
        if (busBusy) st.loadLow = 1'b1;
        else if (timerZero) begin
          st.loadHigh = 1'b1;
          nxt = S_HOLD;
        end
      end
      S_SETUP: if (timerZero) begin
        st.loadHigh = 1'b1;
        nxt = S_HOLD;
      end
      S_HOLD: if (timerZero) begin
        st.loadLow   = 1'b1;
        st.loadFirst = 1'b1;
        nxt = S_BLOW;
      end
      S_BLOW: if (timerZero) begin
        st.loadHigh = 1'b1;
        nxt = S_BHIGH;
      end
      S_BHIGH: begin
        if (!lastBit && sdaDrive && !sdaIn) begin
          arbNx = 1'b1;
          nxt = S_IDLE;
        end else if (timerZero) begin
          if (lastBit) begin
            st.captureAck = 1'b1;
            if (sdaIn || !moreBytes) begin
              doneNx = 1'b1;
              nxt = S_IDLE;
            end else begin
              st.loadSecond = 1'b1;
              st.loadLow    = 1'b1;
              nxt = S_BLOW;
            end
          end else begin
            st.shiftBit = 1'b1;
            st.loadLow  = 1'b1;
            nxt = S_BLOW;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      addrDone  <= 1'b0;
      arbLost   <= 1'b0;
      slaveMode <= 1'b0;
    end else begin
      state    <= nxt;
      addrDone <= doneNx;
      arbLost  <= arbNx;
      if (arbNx)                             slaveMode <= 1'b1;
      else if (state == S_IDLE && startSet)  slaveMode <= 1'b0;
    end
  end

  assign sclOut       = (state != S_BLOW);
  assign startPending = (state != S_IDLE);

  // R10
  arb_slave_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> slaveMode);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrDone |=> !addrDone);

  // R2
  done_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrDone || arbLost) |-> !startPending);

endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_addr_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgTenBit,
  input  logic [9:0]       cfgAddr,
  input  logic             cfgRead,
  input  logic             cfgHeadOnly,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             startSet,
  input  logic             busBusy,
  input  logic [CNT_W-1:0] sclLowCnt,
  input  logic [CNT_W-1:0] sclHighCnt,
  input  logic             sdaIn,
  output logic             sclOut,
  output logic             sdaOut,
  output logic             startPending,
  output logic             addrDone,
  output logic             ackBit,
  output logic             arbLost,
  output logic             slaveMode,
  output logic             curTenBit,
  output logic [9:0]       curAddr,
  output logic             curRead,
  output logic             curHeadOnly,
  output logic [7:0]       curCount
);

  seqStrobe_t st;
  logic timerZero, lastBit, moreBytes;

  i2c_addr_seq_ctrl i_ctrl (
    .clk, .rstN, .startSet, .busBusy, .sdaIn,
    .timerZero, .lastBit, .moreBytes, .sdaDrive(sdaOut),
    .st, .sclOut, .startPending, .addrDone, .arbLost, .slaveMode
  );

  i2c_addr_seq_dp #(.CNT_W(CNT_W), .LEN_W(LEN_W)) i_dp (
    .clk, .rstN, .st, .cfgWrEn, .cfgTenBit, .cfgAddr, .cfgRead,
    .cfgHeadOnly, .cfgLen, .sclLowCnt, .sclHighCnt, .sdaIn,
    .timerZero, .lastBit, .moreBytes, .sdaDrive(sdaOut), .ackBit,
    .curTenBit, .curAddr, .curRead, .curHeadOnly, .curCount
  );

  // R6
  sda_no_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startPending && $past(startPending) && sclOut && $past(sclOut)) |-> !$rose(sdaOut));

endmodule

// File: tb/test_i2c_addr_seq.sv
module test_i2c_addr_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0, cfgTenBit = 0, cfgRead = 0, cfgHeadOnly = 0;
  logic [9:0] cfgAddr = '0;
  logic [15:0] cfgLen = '0;
  logic startSet = 0;
  logic busyBase = 0, busyPulse = 0, pullNow = 0;
  logic [7:0] sclLowCnt = 8'd3, sclHighCnt = 8'd2;
  logic busBusy, sdaIn;
  logic sclOut, sdaOut, startPending, addrDone, ackBit, arbLost, slaveMode;
  logic curTenBit, curRead, curHeadOnly;
  logic [9:0] curAddr;
  logic [7:0] curCount;

  assign busBusy = busyBase | busyPulse;
  assign sdaIn   = sdaOut & ~pullNow;

  always #10 clk = ~clk;

  i2c_addr_seq i_i2c_addr_seq (
    .clk, .rstN, .cfgWrEn, .cfgTenBit, .cfgAddr, .cfgRead, .cfgHeadOnly,
    .cfgLen, .startSet, .busBusy, .sclLowCnt, .sclHighCnt, .sdaIn,
    .sclOut, .sdaOut, .startPending, .addrDone, .ackBit, .arbLost,
    .slaveMode, .curTenBit, .curAddr, .curRead, .curHeadOnly, .curCount
  );

  typedef struct {
    logic scl, sda, done, arb, pend, pull, busy;
    int   tag;
  } ent_t;

  ent_t q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // scenario knobs
  logic       mTen, mRead, mHead, mRep, ackH, ackL;
  logic [9:0] mAddr;
  int         arbAt, busyAt, wrAt;

  task automatic chk(input int tag, input string nm, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic pushE(input logic scl, sda, done, arb, pend, pull, busy, input int tag);
    ent_t e;
    e.scl = scl; e.sda = sda; e.done = done; e.arb = arb;
    e.pend = pend; e.pull = pull; e.busy = busy; e.tag = tag;
    q.push_back(e);
  endtask

  // behavioural expected bus trace built from the requirements
  task automatic build();
    logic lastSda, v, p, ack;
    logic [7:0] b0, b1, cur;
    int nb, bt, L, H;
    L = int'(sclLowCnt); H = int'(sclHighCnt);
    q.delete();
    lastSda = 1'b1;
    // R3 bus-free wait, R4 repeated-start setup
    if (!mRep && busyAt >= 0)
      for (int j = 0; j <= busyAt; j++) pushE(1, 1, 0, 0, 1, 0, j == busyAt, 3);
    for (int j = 0; j <= L; j++) pushE(1, 1, 0, 0, 1, 0, 0, mRep ? 4 : 3);
    // R5 start hold
    pushE(1, 1, 0, 0, 1, 0, 0, 5);
    for (int j = 0; j < H; j++) pushE(1, 0, 0, 0, 1, 0, 0, 5);
    lastSda = 1'b0;
    // R7 byte formats, R8 header-only
    b0 = mTen ? {5'b11110, mAddr[9:8], mRead} : {mAddr[6:0], mRead};
    b1 = mAddr[7:0];
    nb = (!mTen || (mRead && mHead)) ? 1 : 2;
    bt = !mTen ? 6 : ((mRead && mHead) ? 8 : 7);
    for (int k = 0; k < nb; k++) begin
      cur = (k == 0) ? b0 : b1;
      ack = (k == 0) ? ackH : ackL;
      for (int i = 0; i < 9; i++) begin
        v = (i < 8) ? cur[7-i] : 1'b1;
        p = (i == 8) && ack;
        pushE(0, lastSda, 0, 0, 1, 0, 0, bt);
        for (int j = 0; j < L; j++) pushE(0, v, 0, 0, 1, p, 0, bt);
        if (k == 0 && i == arbAt) begin
          // R10 competitor pulls SDA low during high phase
          pushE(1, v, 0, 0, 1, 1, 0, 10);
          pushE(1, 1, 0, 1, 0, 0, 0, 10);
          pushE(1, 1, 0, 0, 0, 0, 0, 10);
          return;
        end
        for (int j = 0; j <= H; j++) pushE(1, v, 0, 0, 1, p, 0, bt);
        lastSda = v;
      end
      if (!ack) begin
        // R9 NACK ends the phase
        pushE(1, 1, 1, 0, 0, 0, 0, 9);
        pushE(1, 1, 0, 0, 0, 0, 0, 9);
        return;
      end
    end
    pushE(1, 1, 1, 0, 0, 0, 0, 9);
    pushE(1, 1, 0, 0, 0, 0, 0, 9);
  endtask

  task automatic cfgWrite(input logic ten, input logic [9:0] a, input logic rd,
                          input logic ho, input logic [15:0] len);
    @(negedge clk);
    cfgTenBit = ten; cfgAddr = a; cfgRead = rd; cfgHeadOnly = ho; cfgLen = len;
    cfgWrEn = 1;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic go();
    ent_t e;
    int cyc;
    build();
    @(negedge clk);
    busyBase = mRep;
    startSet = 1;
    @(negedge clk);
    startSet = 0;
    cyc = 0;
    while (q.size() > 0) begin
      e = q.pop_front();
      pullNow = e.pull;
      busyPulse = e.busy;
      if (cyc == wrAt) begin
        // R11 write and R2 second start while pending, both ignored
        cfgTenBit = 0; cfgAddr = 10'h3FF; cfgRead = 1; cfgHeadOnly = 1; cfgLen = 16'd9;
        cfgWrEn = 1; startSet = 1;
      end else begin
        cfgWrEn = 0; startSet = 0;
      end
      chk(e.tag, "sclOut", sclOut, e.scl);
      chk(e.tag, "sdaOut", sdaOut, e.sda);
      chk(9, "addrDone", addrDone, e.done);
      chk(10, "arbLost", arbLost, e.arb);
      chk(2, "startPending", startPending, e.pend);
      @(negedge clk);
      cyc++;
    end
    pullNow = 0; busyPulse = 0; busyBase = 0; cfgWrEn = 0; startSet = 0;
  endtask

  task automatic setCase(input logic ten, input logic [9:0] a, input logic rd,
                         input logic ho, input logic rep);
    mTen = ten; mAddr = a; mRead = rd; mHead = ho; mRep = rep;
    ackH = 1; ackL = 1; arbAt = -1; busyAt = -1; wrAt = -1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "sclOut reset", sclOut, 1);
    chk(1, "sdaOut reset", sdaOut, 1);
    chk(1, "startPending reset", startPending, 0);
    chk(1, "addrDone reset", addrDone, 0);
    chk(1, "arbLost reset", arbLost, 0);
    chk(1, "slaveMode reset", slaveMode, 0);
    chk(1, "ackBit reset", ackBit, 1);
    rstN = 1;
    @(negedge clk);

    // R12 saturation, R6 7-bit write with ACK
    cfgWrite(0, 10'h05A, 0, 0, 16'd300);
    chk(12, "curCount saturate", curCount, 255);
    chk(11, "curAddr idle write", curAddr, 10'h05A);
    sclLowCnt = 3; sclHighCnt = 2;
    setCase(0, 10'h05A, 0, 0, 0);
    go();
    chk(9, "ackBit after ACK", ackBit, 0);

    // R7 10-bit write, R11 locked write, R2 ignored second start
    cfgWrite(1, 10'h2C7, 0, 0, 16'd5);
    chk(12, "curCount small", curCount, 5);
    setCase(1, 10'h2C7, 0, 0, 0);
    wrAt = 20;
    go();
    chk(11, "curAddr locked", curAddr, 10'h2C7);
    chk(11, "curTenBit locked", curTenBit, 1);
    chk(11, "curRead locked", curRead, 0);
    chk(11, "curHeadOnly locked", curHeadOnly, 0);
    chk(11, "curCount locked", curCount, 5);
    chk(2, "no restart", startPending, 0);

    // R8 header-only read, R4 repeated start
    cfgWrite(1, 10'h1B3, 1, 1, 16'd255);
    chk(12, "curCount 255", curCount, 255);
    sclLowCnt = 2; sclHighCnt = 4;
    setCase(1, 10'h1B3, 1, 1, 1);
    go();

    // R9 NACK on header of a full 10-bit read
    cfgWrite(1, 10'h3A5, 1, 0, 16'd1);
    setCase(1, 10'h3A5, 1, 0, 0);
    ackH = 0;
    go();
    chk(9, "ackBit after NACK", ackBit, 1);

    // R3 busy restarts bus-free wait, 7-bit read
    cfgWrite(0, 10'h033, 1, 0, 16'd2);
    sclLowCnt = 4; sclHighCnt = 1;
    setCase(0, 10'h033, 1, 0, 0);
    busyAt = 2;
    go();

    // R10 arbitration loss on third bit
    cfgWrite(0, 10'h07F, 1, 0, 16'd2);
    sclLowCnt = 2; sclHighCnt = 2;
    setCase(0, 10'h07F, 1, 0, 0);
    arbAt = 2;
    go();
    chk(10, "slaveMode set", slaveMode, 1);
    chk(10, "ackBit untouched", ackBit, 0);

    // R10 next start clears slaveMode
    cfgWrite(0, 10'h012, 0, 0, 16'd3);
    sclLowCnt = 1; sclHighCnt = 1;
    setCase(0, 10'h012, 0, 0, 0);
    go();
    chk(10, "slaveMode cleared", slaveMode, 0);

    finishRun();
  end

endmodule